// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit channel of a packet DMA. Software builds a chain of buffer descriptors in a descriptor RAM local to the block and starts the channel by writing the address of the first descriptor into the head register. The engine reads each descriptor, pulls the buffer it points to out of a byte-wide buffer memory and sends those bytes on a valid/ready byte stream. The stream carries start and end markers. When a buffer has been sent, the engine writes the descriptor's mode word back with the ownership bit handed to software. It then follows the next pointer until it reaches a null pointer.

The engine hands ownership back through one bit in each descriptor. When it finishes a descriptor whose next pointer is null, it sets an end-of-queue flag in that descriptor. Software that appends to a chain reads this flag to decide whether it must write the head register again to restart the channel. A completion register holds the last descriptor the engine finished. Software acknowledges that descriptor by writing the same address back. A control bit gates all fetching. Clearing it stops the channel cleanly between bytes.

Descriptor pointers are word addresses in the descriptor RAM, and the value 0 is the null pointer. A descriptor takes four consecutive words starting at the address in its pointer:
- word +0: next pointer
- word +1: buffer byte address
- word +2: buffer length, in bits 10:0
- word +3: mode word

In the mode word, bit 31 is start of packet, bit 30 is end of packet, bit 29 is the owner bit (1 = engine owns the descriptor) and bit 28 is end of queue. Bits 10:0 of the mode word carry the packet length for software.

The register port has three registers:

| Index | Register | Contents |
|---|---|---|
| 0 | control | bit 0 = enable |
| 1 | head | descriptor pointer |
| 2 | completion | descriptor pointer |

Index 3 reads as zero.

Top module: `pkt_chain_dma`

## Requirements
- R1: After reset the control, head and completion registers read 0, `tx_valid` is low and `done_unacked` is low.
- R2: While enable is set and the engine is idle, a write of a nonzero pointer to the head register starts a walk of the chain. The head register reads nonzero while a descriptor is in flight. It reads 0 once the engine has finished a descriptor whose next pointer (word +0) is 0.
- R3: For each owned descriptor the stream carries the bytes at buffer addresses base .. base+len-1 in ascending order. `tx_first` is high on the first byte only when mode bit 31 is set, and `tx_last` is high on the final byte only when mode bit 30 is set.
- R4: After a descriptor has been sent, its mode word (word +3) has bit 29 cleared and every other bit unchanged, except that bit 28 is set when the next pointer is 0.
- R5: A fetched descriptor whose mode bit 29 is clear sends no byte and leaves its mode word unchanged. The head register returns to 0.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_first` and `tx_last` hold their values.
- R7: After a chain has ended with end of queue, software can link a new descriptor to it. Writing the new descriptor's address to the head register then sends that descriptor.
- R8: Clearing control bit 0 completes the byte being offered and then stops the stream, and the head register keeps its value. Setting the bit again sends the remaining bytes in order.
- R9: A head-register write while a descriptor is being fetched, sent or written back has no effect.
- R10: The completion register (index 2) reads the address of the last finished descriptor, and `done_unacked` rises when a descriptor finishes. Writing that address to index 2 clears `done_unacked`. Writing any other value leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| dsc_we | input | 1 | Host write strobe into the descriptor RAM |
| dsc_addr | input | DESC_AW | Host descriptor RAM word address |
| dsc_wdata | input | 32 | Host descriptor RAM write data |
| dsc_rdata | output | 32 | Host descriptor RAM read data, one cycle after the address |
| buf_rd_en | output | 1 | Buffer memory read strobe |
| buf_addr | output | BUF_AW | Buffer memory byte address |
| buf_rdata | input | 8 | Buffer memory read data, one cycle after the strobe |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of a start-of-packet descriptor |
| tx_last | output | 1 | Final byte of an end-of-packet descriptor |
| tx_ready | input | 1 | Downstream ready |
| done_unacked | output | 1 | A finished descriptor awaits acknowledgement |

## Verification
The bench builds the block with DESC_AW = 6 and BUF_AW = 8. That gives a 64-word descriptor RAM holding sixteen descriptors and a 256-byte buffer memory, so every descriptor and every buffer in the tests can be laid out by hand at small, readable addresses.

The bench keeps the host-priority default. Several chains, including an owner-clear stop and an end-of-queue append, fit in a few hundred cycles.

Under these sizes a stall driven from the bench and a mid-buffer enable drop can both be placed at chosen bytes. The completion pointer can be compared against exact small addresses.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
   localparam int MODE_SOP  = 31;
   localparam int MODE_EOP  = 30;
   localparam int MODE_OWN  = 29;
   localparam int MODE_EOQ  = 28;
   localparam int PKT_LEN_W = 11;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_HEAD = 2'd1;
   localparam logic [1:0] REG_DONE = 2'd2;

   typedef enum logic [2:0] {
      WK_IDLE, WK_FETCH, WK_CHECK, WK_MOVE, WK_WBACK
   } walk_state_e;

   typedef enum logic [1:0] {
      PM_IDLE, PM_READ, PM_LAND, PM_HOLD
   } pump_state_e;
endpackage

// File: rtl/pcd_desc_ram.sv
module pcd_desc_ram #(
   parameter int AW         = 6,
   parameter int DW         = 32,
   parameter bit HOST_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          e_we,
   input  logic [AW-1:0] e_addr,
   input  logic [DW-1:0] e_wdata,
   output logic [DW-1:0] e_rdata,
   input  logic          h_we,
   input  logic [AW-1:0] h_addr,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 3 || AW > 12) begin : g_bad_aw
      $error("pcd_desc_ram: AW out of range");
   end

   logic [DW-1:0] mem [DEPTH];

   // Same-word collision: the later assignment wins.
   if (HOST_FIRST) begin : g_host_wins
      always_ff @(posedge clk) begin
         if (e_we) mem[e_addr] <= e_wdata;
         if (h_we) mem[h_addr] <= h_wdata;
      end
   end else begin : g_engine_wins
      always_ff @(posedge clk) begin
         if (h_we) mem[h_addr] <= h_wdata;
         if (e_we) mem[e_addr] <= e_wdata;
      end
   end

   always_ff @(posedge clk) begin
      e_rdata <= mem[e_addr];
      h_rdata <= mem[h_addr];
   end
endmodule

// File: rtl/pcd_byte_pump.sv
module pcd_byte_pump
   import pcd_pkg::*;
#(
   parameter int BAW = 8,
   parameter int LW  = PKT_LEN_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic           go,
   input  logic [BAW-1:0] base,
   input  logic [LW-1:0]  len,
   input  logic           sop,
   input  logic           eop,
   output logic           done,
   output logic           buf_rd_en,
   output logic [BAW-1:0] buf_addr,
   input  logic [7:0]     buf_rdata,
   output logic           tx_valid,
   output logic [7:0]     tx_data,
   output logic           tx_first,
   output logic           tx_last,
   input  logic           tx_ready
);
   pump_state_e    st;
   logic [BAW-1:0] addr_q;
   logic [LW-1:0]  rem_q;
   logic           sop_q, eop_q, first_q, done_q;
   logic [7:0]     data_q;
   logic           hs, more, issue;

   assign hs    = (st == PM_HOLD) && tx_ready;
   assign more  = (rem_q != LW'(1));
   assign issue = en && ((st == PM_READ) || (hs && more));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= PM_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
         sop_q   <= 1'b0;
         eop_q   <= 1'b0;
         first_q <= 1'b0;
         done_q  <= 1'b0;
         data_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (issue) addr_q <= addr_q + 1'b1;
         case (st)
            PM_IDLE: if (go) begin
               addr_q  <= base;
               rem_q   <= len;
               sop_q   <= sop;
               eop_q   <= eop;
               first_q <= 1'b1;
               if (len == '0) done_q <= 1'b1;
               else           st     <= PM_READ;
            end
            PM_READ: if (issue) st <= PM_LAND;
            PM_LAND: begin
               data_q <= buf_rdata;
               st     <= PM_HOLD;
            end
            PM_HOLD: if (tx_ready) begin
               rem_q   <= rem_q - 1'b1;
               first_q <= 1'b0;
               if (!more) begin
                  st     <= PM_IDLE;
                  done_q <= 1'b1;
               end else if (en) begin
                  st <= PM_LAND;
               end else begin
                  st <= PM_READ;
               end
            end
            default: st <= PM_IDLE;
         endcase
      end
   end

   assign done      = done_q;
   assign buf_rd_en = issue;
   assign buf_addr  = addr_q;
   assign tx_valid  = (st == PM_HOLD);
   assign tx_data   = data_q;
   assign tx_first  = tx_valid && sop_q && first_q;
   assign tx_last   = tx_valid && eop_q && !more;
endmodule

// File: rtl/pcd_chain_walker.sv
module pcd_chain_walker
   import pcd_pkg::*;
#(
   parameter int DAW = 6,
   parameter int BAW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 head_wr,
   input  logic [DAW-1:0]       head_wdata,
   output logic [DAW-1:0]       head_q,
   output logic                 ram_we,
   output logic [DAW-1:0]       ram_addr,
   output logic [31:0]          ram_wdata,
   input  logic [31:0]          ram_rdata,
   output logic                 pump_go,
   output logic [BAW-1:0]       pump_base,
   output logic [PKT_LEN_W-1:0] pump_len,
   output logic                 pump_sop,
   output logic                 pump_eop,
   input  logic                 pump_done,
   output logic                 cmpl,
   output logic [DAW-1:0]       cmpl_ptr
);
   localparam int WORDS = 4;

   walk_state_e          st;
   logic [DAW-1:0]       cur_q, head_r, nxt_q;
   logic [BAW-1:0]       bptr_q;
   logic [PKT_LEN_W-1:0] len_q;
   logic [31:0]          mode_q;
   logic [2:0]           k_q;
   logic                 at_tail;
   logic [31:0]          mode_wb;

   assign at_tail = (nxt_q == '0);

   always_comb begin
      mode_wb           = mode_q;
      mode_wb[MODE_OWN] = 1'b0;
      if (at_tail) mode_wb[MODE_EOQ] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= WK_IDLE;
         cur_q  <= '0;
         head_r <= '0;
         nxt_q  <= '0;
         bptr_q <= '0;
         len_q  <= '0;
         mode_q <= '0;
         k_q    <= '0;
      end else begin
         case (st)
            WK_IDLE: begin
               if (head_wr) begin
                  head_r <= head_wdata;
               end else if (en && head_r != '0) begin
                  cur_q <= head_r;
                  k_q   <= '0;
                  st    <= WK_FETCH;
               end
            end
            WK_FETCH: begin
               case (k_q)
                  3'd1:    nxt_q  <= ram_rdata[DAW-1:0];
                  3'd2:    bptr_q <= ram_rdata[BAW-1:0];
                  3'd3:    len_q  <= ram_rdata[PKT_LEN_W-1:0];
                  3'd4:    mode_q <= ram_rdata;
                  default: ;
               endcase
               if (k_q == 3'(WORDS)) st  <= WK_CHECK;
               else                  k_q <= k_q + 3'd1;
            end
            WK_CHECK: begin
               if (mode_q[MODE_OWN]) begin
                  st <= WK_MOVE;
               end else begin
                  head_r <= '0;
                  st     <= WK_IDLE;
               end
            end
            WK_MOVE: if (pump_done) st <= WK_WBACK;
            WK_WBACK: begin
               head_r <= nxt_q;
               st     <= WK_IDLE;
            end
            default: st <= WK_IDLE;
         endcase
      end
   end

   assign head_q    = head_r;
   assign ram_we    = (st == WK_WBACK);
   assign ram_addr  = (st == WK_WBACK) ? cur_q + DAW'(WORDS - 1)
                                       : cur_q + DAW'(k_q[1:0]);
   assign ram_wdata = mode_wb;
   assign pump_go   = (st == WK_CHECK) && mode_q[MODE_OWN];
   assign pump_base = bptr_q;
   assign pump_len  = len_q;
   assign pump_sop  = mode_q[MODE_SOP];
   assign pump_eop  = mode_q[MODE_EOP];
   assign cmpl      = (st == WK_WBACK);
   assign cmpl_ptr  = cur_q;
endmodule

// File: rtl/pkt_chain_dma.sv
module pkt_chain_dma
   import pcd_pkg::*;
#(
   parameter int DESC_AW       = 6,
   parameter int BUF_AW        = 8,
   parameter bit HOST_PRIORITY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [1:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               dsc_we,
   input  logic [DESC_AW-1:0] dsc_addr,
   input  logic [31:0]        dsc_wdata,
   output logic [31:0]        dsc_rdata,
   output logic               buf_rd_en,
   output logic [BUF_AW-1:0]  buf_addr,
   input  logic [7:0]         buf_rdata,
   output logic               tx_valid,
   output logic [7:0]         tx_data,
   output logic               tx_first,
   output logic               tx_last,
   input  logic               tx_ready,
   output logic               done_unacked
);
   localparam int PAD = 32 - DESC_AW;

   if (DESC_AW < 3 || DESC_AW > 12) begin : g_bad_desc_aw
      $error("pkt_chain_dma: DESC_AW out of range");
   end
   if (BUF_AW < 1 || BUF_AW > 32) begin : g_bad_buf_aw
      $error("pkt_chain_dma: BUF_AW out of range");
   end

   logic                 en_q, unacked_q;
   logic [DESC_AW-1:0]   done_ptr, head_ptr, cmpl_ptr;
   logic                 cmpl, head_wr;
   logic                 e_we;
   logic [DESC_AW-1:0]   e_addr;
   logic [31:0]          e_wdata, e_rdata;
   logic                 p_go, p_sop, p_eop, p_done;
   logic [BUF_AW-1:0]    p_base;
   logic [PKT_LEN_W-1:0] p_len;

   assign head_wr = reg_wr && (reg_addr == REG_HEAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         done_ptr  <= '0;
         unacked_q <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == REG_CTRL) en_q <= reg_wdata[0];
         if (cmpl) begin
            done_ptr  <= cmpl_ptr;
            unacked_q <= 1'b1;
         end else if (reg_wr && reg_addr == REG_DONE &&
                      reg_wdata == {{PAD{1'b0}}, done_ptr}) begin
            unacked_q <= 1'b0;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         REG_CTRL: reg_rdata = {31'd0, en_q};
         REG_HEAD: reg_rdata = {{PAD{1'b0}}, head_ptr};
         REG_DONE: reg_rdata = {{PAD{1'b0}}, done_ptr};
         default:  reg_rdata = '0;
      endcase
   end

   assign done_unacked = unacked_q;

   pcd_desc_ram #(.AW(DESC_AW), .DW(32), .HOST_FIRST(HOST_PRIORITY)) u_ram (
      .clk     (clk),
      .e_we    (e_we),
      .e_addr  (e_addr),
      .e_wdata (e_wdata),
      .e_rdata (e_rdata),
      .h_we    (dsc_we),
      .h_addr  (dsc_addr),
      .h_wdata (dsc_wdata),
      .h_rdata (dsc_rdata)
   );

   pcd_chain_walker #(.DAW(DESC_AW), .BAW(BUF_AW)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en_q),
      .head_wr    (head_wr),
      .head_wdata (reg_wdata[DESC_AW-1:0]),
      .head_q     (head_ptr),
      .ram_we     (e_we),
      .ram_addr   (e_addr),
      .ram_wdata  (e_wdata),
      .ram_rdata  (e_rdata),
      .pump_go    (p_go),
      .pump_base  (p_base),
      .pump_len   (p_len),
      .pump_sop   (p_sop),
      .pump_eop   (p_eop),
      .pump_done  (p_done),
      .cmpl       (cmpl),
      .cmpl_ptr   (cmpl_ptr)
   );

   pcd_byte_pump #(.BAW(BUF_AW), .LW(PKT_LEN_W)) u_pump (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .go        (p_go),
      .base      (p_base),
      .len       (p_len),
      .sop       (p_sop),
      .eop       (p_eop),
      .done      (p_done),
      .buf_rd_en (buf_rd_en),
      .buf_addr  (buf_addr),
      .buf_rdata (buf_rdata),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_first  (tx_first),
      .tx_last   (tx_last),
      .tx_ready  (tx_ready)
   );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
   parameter int DAW = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic           tx_valid,
   input logic           tx_ready,
   input logic [7:0]     tx_data,
   input logic           tx_first,
   input logic           tx_last,
   input logic           en_q,
   input logic [DAW-1:0] head_ptr,
   input logic           cmpl,
   input logic [DAW-1:0] done_ptr,
   input logic           reg_wr,
   input logic [1:0]     reg_addr,
   input logic [31:0]    reg_wdata,
   input logic           done_unacked
);
   localparam int PAD = 32 - DAW;

   // R6: an offered byte holds while the sink stalls
   a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) &&
                                $stable(tx_first) && $stable(tx_last));

   // R2: bytes only leave while a descriptor is in flight
   a_r2_head_live: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> head_ptr != '0);

   // R8: with enable low for two cycles no new byte appears
   a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q && $past(!en_q) && !tx_valid |=> !tx_valid);

   // R10: a completion raises the pending flag
   a_r10_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl |=> done_unacked);

   // R10: a matching acknowledgement clears the flag
   a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_addr == 2'd2 && reg_wdata == {{PAD{1'b0}}, done_ptr} && !cmpl
      |=> !done_unacked);
endmodule

bind pkt_chain_dma pcd_checker #(.DAW(DESC_AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .tx_data      (tx_data),
   .tx_first     (tx_first),
   .tx_last      (tx_last),
   .en_q         (en_q),
   .head_ptr     (head_ptr),
   .cmpl         (cmpl),
   .done_ptr     (done_ptr),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .done_unacked (done_unacked)
);

// File: tb/sim_pkt_chain_dma.sv
`timescale 1ns/1ps
module sim_pkt_chain_dma;
   localparam int DAW = 6;
   localparam int BAW = 8;
   localparam logic [31:0] M_SOP = 32'h8000_0000;
   localparam logic [31:0] M_EOP = 32'h4000_0000;
   localparam logic [31:0] M_OWN = 32'h2000_0000;
   localparam logic [31:0] M_EOQ = 32'h1000_0000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0;
   logic [1:0]     reg_addr = '0;
   logic [31:0]    reg_wdata = '0;
   logic [31:0]    reg_rdata;
   logic           dsc_we = 1'b0;
   logic [DAW-1:0] dsc_addr = '0;
   logic [31:0]    dsc_wdata = '0;
   logic [31:0]    dsc_rdata;
   logic           buf_rd_en;
   logic [BAW-1:0] buf_addr;
   logic [7:0]     buf_rdata = '0;
   logic           tx_valid, tx_first, tx_last;
   logic [7:0]     tx_data;
   logic           tx_ready = 1'b0;
   logic           done_unacked;

   int n_chk = 0;
   int n_bad = 0;
   int got   = 0;
   int cyc   = 0;
   int rdy_mode = 0;
   bit done_flag = 1'b0;
   logic [9:0] exp_q[$];
   logic [7:0] bmem [256];

   always #2.5 clk = ~clk;

   pkt_chain_dma #(.DESC_AW(DAW), .BUF_AW(BAW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dsc_we(dsc_we), .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata), .dsc_rdata(dsc_rdata),
      .buf_rd_en(buf_rd_en), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
      .tx_ready(tx_ready), .done_unacked(done_unacked)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // buffer memory: one-cycle read latency
   always @(posedge clk) if (buf_rd_en) buf_rdata <= bmem[buf_addr];

   // stream reference model, compared every clock
   logic       stall_prev = 1'b0;
   logic [9:0] held_prev = '0;
   always @(negedge clk) begin
      cyc++;
      case (rdy_mode)
         0:       tx_ready = 1'b1;
         1:       tx_ready = (cyc % 3) != 0;
         default: tx_ready = 1'b0;
      endcase
      if (rst_n) begin
         if (stall_prev)
            chk(tx_valid && {tx_first, tx_last, tx_data} == held_prev,
                "R6", "stalled byte", {tx_valid, tx_first, tx_last, tx_data},
                {1'b1, held_prev});
         if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected byte", tx_data, 0);
            end else begin
               logic [9:0] e;
               e = exp_q.pop_front();
               chk({tx_first, tx_last, tx_data} == e, "R3", "byte/markers",
                   {tx_first, tx_last, tx_data}, e);
            end
            got++;
         end
         stall_prev = tx_valid && !tx_ready;
         held_prev  = {tx_first, tx_last, tx_data};
      end
   end

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic dsc_write(input int a, input logic [31:0] d);
      @(negedge clk);
      dsc_we = 1'b1; dsc_addr = DAW'(a); dsc_wdata = d;
      @(negedge clk);
      dsc_we = 1'b0;
   endtask

   task automatic dsc_read(input int a, output logic [31:0] d);
      @(negedge clk);
      dsc_addr = DAW'(a);
      @(negedge clk);
      d = dsc_rdata;
   endtask

   task automatic put_desc(input int p, input int nxt, input int bp, input int len,
                           input logic [31:0] mode);
      dsc_write(p,     32'(nxt));
      dsc_write(p + 1, 32'(bp));
      dsc_write(p + 2, 32'(len));
      dsc_write(p + 3, mode);
   endtask

   task automatic expect_buf(input int bp, input int len, input bit sop, input bit eop);
      for (int i = 0; i < len; i++)
         exp_q.push_back({sop && i == 0, eop && i == len - 1, bmem[bp + i]});
   endtask

   task automatic wait_idle();
      logic [31:0] h;
      for (int i = 0; i < 3000; i++) begin
         reg_read(2'd1, h);
         if (h == 0) return;
      end
   endtask

   initial begin
      logic [31:0] v;
      int g0, g1;
      for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 37 + 5);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_read(2'd0, v); chk(v == 0, "R1", "control", v, 0);
      reg_read(2'd1, v); chk(v == 0, "R1", "head", v, 0);
      reg_read(2'd2, v); chk(v == 0, "R1", "completion", v, 0);
      chk(!tx_valid && !done_unacked, "R1", "valid/unacked", {tx_valid, done_unacked}, 0);

      // R2/R3/R4/R10: three-descriptor chain, stuttering sink
      put_desc(4,  8,  16, 3, M_SOP | M_OWN | 32'd8);
      put_desc(8,  12, 40, 5, M_EOP | M_OWN | 32'd8);
      put_desc(12, 0, 100, 1, M_SOP | M_EOP | M_OWN | 32'd1);
      expect_buf(16, 3, 1, 0);
      expect_buf(40, 5, 0, 1);
      expect_buf(100, 1, 1, 1);
      rdy_mode = 1;
      g0 = got;
      reg_write(2'd0, 32'd1);
      reg_write(2'd1, 32'd4);
      reg_read(2'd1, v); chk(v != 0, "R2", "head busy", v, 4);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0 && got - g0 == 9, "R3", "chain byte count", got - g0, 9);
      reg_read(2'd1, v); chk(v == 0, "R2", "head after tail", v, 0);
      dsc_read(7,  v); chk(v == (M_SOP | 32'd8), "R4", "mode A", v, M_SOP | 32'd8);
      dsc_read(11, v); chk(v == (M_EOP | 32'd8), "R4", "mode B", v, M_EOP | 32'd8);
      dsc_read(15, v); chk(v == (M_SOP | M_EOP | M_EOQ | 32'd1), "R4", "mode C",
                           v, M_SOP | M_EOP | M_EOQ | 32'd1);
      dsc_read(4, v);  chk(v == 8, "R4", "next A kept", v, 8);
      reg_read(2'd2, v); chk(v == 12, "R10", "completion ptr", v, 12);
      chk(done_unacked, "R10", "unacked set", done_unacked, 1);
      reg_write(2'd2, 32'd8);
      chk(done_unacked, "R10", "wrong ack ignored", done_unacked, 1);
      reg_write(2'd2, 32'd12);
      chk(!done_unacked, "R10", "ack clears", done_unacked, 0);

      // R5: descriptor not owned by the engine
      put_desc(16, 0, 60, 4, M_SOP | M_EOP | 32'd4);
      g0 = got;
      reg_write(2'd1, 32'd16);
      repeat (20) @(negedge clk);
      reg_read(2'd1, v); chk(v == 0, "R5", "head cleared", v, 0);
      chk(got == g0, "R5", "no bytes", got - g0, 0);
      dsc_read(19, v); chk(v == (M_SOP | M_EOP | 32'd4), "R5", "mode untouched",
                           v, M_SOP | M_EOP | 32'd4);
      reg_read(2'd2, v); chk(v == 12, "R5", "no completion", v, 12);

      // R7: append after end of queue, restart through head
      put_desc(20, 0, 120, 2, M_SOP | M_EOP | M_OWN | 32'd2);
      dsc_write(12, 32'd20);
      dsc_read(15, v); chk((v & M_EOQ) != 0, "R7", "eoq seen", v, M_EOQ);
      expect_buf(120, 2, 1, 1);
      g0 = got;
      reg_write(2'd1, 32'd20);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0 && got - g0 == 2, "R7", "restart bytes", got - g0, 2);
      reg_read(2'd2, v); chk(v == 20, "R7", "completion E", v, 20);

      // R8/R9: enable drop mid-buffer, head write while busy
      put_desc(24, 0, 200, 6, M_SOP | M_EOP | M_OWN | 32'd6);
      expect_buf(200, 6, 1, 1);
      rdy_mode = 0;
      g0 = got;
      reg_write(2'd1, 32'd24);
      for (int i = 0; i < 200 && got - g0 < 2; i++) @(negedge clk);
      reg_write(2'd0, 32'd0);
      repeat (30) @(negedge clk);
      g1 = got;
      repeat (30) @(negedge clk);
      chk(got == g1 && got - g0 < 6, "R8", "stream halted", got - g0, g1 - g0);
      chk(!tx_valid, "R8", "no byte offered", tx_valid, 0);
      reg_read(2'd1, v); chk(v == 24, "R8", "head kept", v, 24);
      reg_write(2'd1, 32'd16);
      reg_read(2'd1, v); chk(v == 24, "R9", "busy head write ignored", v, 24);
      reg_write(2'd0, 32'd1);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0 && got - g0 == 6, "R8", "resume order", got - g0, 6);

      // R6: long stall on the first byte
      put_desc(28, 0, 10, 3, M_SOP | M_EOP | M_OWN | 32'd3);
      expect_buf(10, 3, 1, 1);
      rdy_mode = 2;
      reg_write(2'd1, 32'd28);
      repeat (20) @(negedge clk);
      chk(tx_valid && tx_data == bmem[10] && tx_first, "R6", "stall offer",
          {tx_valid, tx_first, tx_data}, {2'b11, bmem[10]});
      rdy_mode = 1;
      wait_idle();
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0 && !tx_valid, "R6", "drain after stall", exp_q.size(), 0);

      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         chk(1'b0, "WD", "watchdog", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule